// File: doc/BRIEF.md
# Programmable Dual-Modulus Prescaler

This block divides an already divided-by-four clock by P or by P+1 and delivers one pulse for each completed output cycle to the swallow counters downstream. A two-bit mode field picks P from four values (8, 16, 32, 64), and a modulus-control input chooses, cycle by cycle, whether that cycle lasts P or P+1 input clocks. The pulse rate is therefore at most one eighth of the input clock, which keeps the downstream counters at a rate they can handle.

Internally, a synchronous core counts passes of four clocks, or five clocks when one extra clock is to be added. A binary pass counter follows it. The mode sets how many of the counter's stages must be full before the cycle ends. Everything runs on the one input clock, with enables, so there are no derived clocks. Mode and modulus control are captured only at cycle boundaries, so a cycle that has started always completes with the ratio it began with.

Top module: `dual_mod_prescaler`

## Requirements
- R1: With `mod_ctl` low, the cycle lengths in input clocks are: `mode_sel` 2'b00 gives 8, 2'b01 gives 16, 2'b10 gives 32, 2'b11 gives 64.
- R2: With `mod_ctl` high, a cycle lasts exactly one input clock longer than the mode's P, giving 9, 17, 33 or 65.
- R3: `mode_sel` and `mod_ctl` are sampled on the rising edge at which `pulse_o` goes high, and that sample sets the length of the next cycle. Changing them at any other time has no effect on the cycle in progress.
- R4: `pulse_o` is a registered pulse, high for exactly one clock. It rises after the last input edge of each cycle.
- R5: While `rst` is high, `pulse_o` is low and the inputs are captured continuously. The first cycle after release uses the values present at the last reset edge, and its pulse follows the L-th rising edge after release, where L is that cycle's length.
- R6: In a P+1 cycle the four/five core adds its extra clock exactly once, in the first pass. Every other pass lasts four clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock, already divided by four upstream |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 2 | Selects P: 00=8, 01=16, 10=32, 11=64 |
| mod_ctl | input | 1 | High selects P+1 for the next cycle |
| pulse_o | output | 1 | One-clock pulse at the end of each cycle |

## Verification
Two things happen on the same clock edge: the end-of-cycle pulse is issued, and the new mode and modulus control are loaded for the following cycle. The bench provokes this overlap by walking every ordered pair of the eight settings across consecutive boundaries. In each cycle it first drives decoy values just after the pulse, then drives the intended values partway through. Each measured cycle length is compared with the length computed from the values present at the previous boundary. A reset asserted in the middle of a cycle checks that the first cycle after release follows the values held during reset.

// File: rtl/dmp_pkg.sv
package dmp_pkg;
  localparam int MODE_W   = 2;
  localparam int NSTG     = 2 ** MODE_W;
  localparam int CORE_DIV = 4;
  localparam int CORE_W   = $clog2(CORE_DIV + 1);

  typedef enum logic [MODE_W-1:0] {
    MODE_P8  = 2'b00,
    MODE_P16 = 2'b01,
    MODE_P32 = 2'b10,
    MODE_P64 = 2'b11
  } mode_e;
endpackage

// File: rtl/dmp_core.sv
module dmp_core
  import dmp_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic mc_in,
  input  logic load,
  output logic pass_end_o
);
  logic [CORE_W-1:0] cnt;
  logic              ext;

  assign pass_end_o = (cnt == (ext ? CORE_W'(CORE_DIV) : CORE_W'(CORE_DIV - 1)));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      ext <= mc_in;
    end else begin
      if (pass_end_o) begin
        cnt <= '0;
        ext <= 1'b0;
      end else begin
        cnt <= cnt + 1'b1;
      end
      if (load) ext <= mc_in;
    end
  end

  // R6: the extra clock is spent once; after a pass ends without reload it is gone
  a_r6_ext_once: assert property (@(posedge clk) disable iff (rst)
    (pass_end_o && !load) |=> !ext);
  // R6: a pass never exceeds five clocks
  a_r6_core_bound: assert property (@(posedge clk) disable iff (rst)
    cnt <= CORE_W'(CORE_DIV));
endmodule

// File: rtl/dmp_stages.sv
module dmp_stages
  import dmp_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              step,
  input  logic              clear,
  input  logic [MODE_W-1:0] sel,
  output logic              term_o
);
  logic [NSTG-1:0] cnt;
  logic [NSTG-1:0] full;

  assign full[0] = cnt[0];
  for (genvar i = 1; i < NSTG; i++) begin : g_full
    assign full[i] = full[i-1] & cnt[i];
  end

  assign term_o = full[sel];

  always_ff @(posedge clk) begin
    if (rst || clear) cnt <= '0;
    else if (step)    cnt <= cnt + 1'b1;
  end

  // R1: pass count stays below the number of passes the mode allows
  a_r1_stage_bound: assert property (@(posedge clk) disable iff (rst)
    (32'(cnt) < (32'd2 << sel)));
endmodule

// File: rtl/dual_mod_prescaler.sv
module dual_mod_prescaler
  import dmp_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] mode_sel,
  input  logic       mod_ctl,
  output logic       pulse_o
);
  mode_e mode_q;
  logic  pass_end;
  logic  term;
  logic  cycle_end;

  assign cycle_end = pass_end & term;

  dmp_core u_core (
    .clk        (clk),
    .rst        (rst),
    .mc_in      (mod_ctl),
    .load       (cycle_end),
    .pass_end_o (pass_end)
  );

  dmp_stages u_stages (
    .clk    (clk),
    .rst    (rst),
    .step   (pass_end),
    .clear  (cycle_end),
    .sel    (mode_q),
    .term_o (term)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= mode_e'(mode_sel);
      pulse_o <= 1'b0;
    end else begin
      if (cycle_end) mode_q <= mode_e'(mode_sel);
      pulse_o <= cycle_end;
    end
  end

  // R4: pulse lasts a single clock
  a_r4_pulse_single: assert property (@(posedge clk) disable iff (rst)
    pulse_o |=> !pulse_o);
  // R5: reset silences the output
  a_r5_reset_quiet: assert property (@(posedge clk)
    rst |=> !pulse_o);
endmodule

// File: tb/dual_mod_prescaler_tb_top.sv
module dual_mod_prescaler_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] mode_sel = 2'b00;
  logic       mod_ctl = 1'b0;
  logic       pulse_o;

  int n_chk  = 0;
  int n_fail = 0;
  int exp_len;
  bit done = 0;

  always #2 clk = ~clk;

  dual_mod_prescaler dut_i (
    .clk(clk), .rst(rst), .mode_sel(mode_sel), .mod_ctl(mod_ctl), .pulse_o(pulse_o)
  );

  function automatic int len_of(input logic [1:0] m, input logic c);
    return (8 << m) + (c ? 1 : 0);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // Measures one cycle: decoys just after the start, intended values midway.
  task automatic one_cycle(input logic [1:0] m, input logic c, input string req);
    int cnt = 0;
    mode_sel = ~m;
    mod_ctl  = ~c;
    while (cnt < 200) begin
      @(negedge clk);
      cnt++;
      if (cnt == 1) check(pulse_o == 1'b0, "R4 width", int'(pulse_o), 0);
      if (cnt == 3) begin
        mode_sel = m;
        mod_ctl  = c;
      end
      if (pulse_o) break;
    end
    check(cnt == exp_len, req, cnt, exp_len);
    exp_len = len_of(m, c);
  endtask

  initial begin
    mode_sel = 2'b00;
    mod_ctl  = 1'b0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check(pulse_o == 1'b0, "R5 reset", int'(pulse_o), 0);
    end
    rst = 1'b0;
    exp_len = 8;
    // R1 R2 R3 R6: every ordered pair of settings across boundaries
    for (int a = 0; a < 8; a++) begin
      for (int b = 0; b < 8; b++) begin
        one_cycle(2'(a >> 1), a[0], "R1/R2/R3/R6 len");
        one_cycle(2'(b >> 1), b[0], "R1/R2/R3/R6 len");
      end
    end
    // R5: reset mid-cycle with 64/65 and extra clock held during reset
    repeat (5) @(negedge clk);
    rst      = 1'b1;
    mode_sel = 2'b11;
    mod_ctl  = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(pulse_o == 1'b0, "R5 reset", int'(pulse_o), 0);
    end
    rst = 1'b0;
    exp_len = 65;
    one_cycle(2'b00, 1'b0, "R5 first cycle");
    one_cycle(2'b01, 1'b1, "R1 after reset");
    one_cycle(2'b00, 1'b0, "R2 after reset");
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule